// File: doc/BRIEF.md
# LED Driver Serial Configuration Path

This block is the configuration front end of a sixteen-channel LED driver. A host shifts brightness words (twelve bits per channel) or current-trim words (six bits per channel) into one serial chain, one bit per shift strobe, highest bit first. A level-sensitive latch input then copies the chain into the brightness register or the trim register, depending on the mode input. The chain's top bit drives a serial output, so several drivers can be cascaded into one long chain.

When a brightness latch completes, the chain is reloaded with a status word. The word carries the per-channel open-LED flags, the over-temperature flag and a copy of the trim settings. The host reads it out while it shifts in the next brightness frame. A select input picks the trim copy shown in that word: either the live trim register, or a fixed nonvolatile image whose every channel reads 0x3F. After a trim write, the first brightness latch is left pending. One more shift strobe, after the latch, commits it.

Top module: `led_cfg_serial`

## Requirements
- R1: Each clock with `shift_en` high and `latch` low moves the chain up one place and puts `sin` into bit 0. The word is sent MSB first. A `shift_en` while `latch` is high is ignored.
- R2: `ser_out` is chain bit 191 when `dc_mode` is 0 and chain bit 95 when `dc_mode` is 1. It changes on the same clock edge that shifts the chain.
- R3: With `dc_mode` 0 and no trim write pending, `latch` high makes `gs_data` equal to the chain on the next clock. While `latch` stays low, `gs_data` and `dc_data` hold their values.
- R4: With `dc_mode` 1, `latch` high makes `dc_data` equal to chain bits 95:0 on the next clock. Channel n occupies bits 6n+5:6n, so channel 15 is shifted in first.
- R5: The clock that sees `latch` fall in brightness mode loads the chain with the status word and performs no shift. In that word, bits 15:0 are the open-LED flags (bit n for channel n), bit 16 is the over-temperature flag, bits 119:24 are the trim data in the R4 layout, and every other bit is 0.
- R6: The status trim field comes from `dc_data` when `dc_src_reg` is 1 and from the nonvolatile image when it is 0.
- R7: `open_flags` is sampled on the clock that sees `latch` fall. Later changes do not reach the status word already taken.
- R8: Once the status word is loaded, `ser_out` shows its bit 191. Each following shift presents the next lower bit, so 192 shifts read the whole word out while the next frame goes in.
- R9: After a trim latch, the next brightness latch leaves `gs_data` and the chain unchanged, and its falling edge loads no status. The first `shift_en` after that latch (with `latch` low and `dc_mode` 0) copies the chain into `gs_data` and loads the status word instead of shifting. This status word uses the open-LED flags sampled at the latch's falling edge.
- R10: The nonvolatile trim image reads 0x3F for every channel, so with `dc_src_reg` 0 the status bits 119:24 are all ones.
- R11: Synchronous reset clears the chain, `gs_data` and `dc_data`, drives `ser_out` to 0 and clears any pending trim-write state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sin | input | 1 | Serial data in |
| shift_en | input | 1 | One-cycle strobe per serial bit |
| latch | input | 1 | Level latch strobe |
| dc_mode | input | 1 | 0: brightness mode (192-bit chain), 1: trim mode (96-bit chain) |
| dc_src_reg | input | 1 | Status trim source: 1 trim register, 0 nonvolatile image |
| open_flags | input | 16 | Per-channel open-LED detector flags |
| thermal_flag | input | 1 | Over-temperature flag |
| ser_out | output | 1 | Serial out (top of active chain) |
| gs_data | output | 192 | Brightness register, channel n at bits 12n+11:12n |
| dc_data | output | 96 | Trim register, channel n at bits 6n+5:6n |

## Verification
Trim frames are built channel by channel, which shows that the field order is right. The bit after the trim latch then shows which chain tap drives the serial output in trim mode. Brightness frames are random 192-bit words. The status readback that rides under the next frame separates the two trim sources, the captured from the later open-LED flags, and the immediate commit from the pending commit that follows a trim write. Directed cases strobe the shift input while the latch is high and shift without latching, which exposes any shift or register update that should not happen.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;

    localparam int NUM_CH     = 16;
    localparam int GS_BITS    = 12;
    localparam int DC_BITS    = 6;
    localparam int GS_LEN     = NUM_CH * GS_BITS;
    localparam int DC_LEN     = NUM_CH * DC_BITS;
    localparam int ST_TEF_POS = NUM_CH;
    localparam int ST_DC_LSB  = 24;

    localparam logic [DC_LEN-1:0] NV_DC_IMAGE = '1;

    typedef enum logic {
        MODE_GS = 1'b0,
        MODE_DC = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_DC_DONE = 2'd1,
        UPD_GS_WAIT = 2'd2
    } upd_state_e;

    typedef struct packed {
        logic shift;
        logic load_gs;
        logic load_dc;
        logic load_stat;
        logic use_cap;
    } cfg_ctl_t;

    function automatic logic [GS_LEN-1:0] pack_status(
        input logic [NUM_CH-1:0] lod,
        input logic              tef,
        input logic [DC_LEN-1:0] dc
    );
        logic [GS_LEN-1:0] w;
        w = '0;
        w[NUM_CH-1:0]            = lod;
        w[ST_TEF_POS]            = tef;
        w[ST_DC_LSB +: DC_LEN]   = dc;
        return w;
    endfunction

endpackage

// File: rtl/cfg_update_ctl.sv
module cfg_update_ctl
    import ledcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              latch,
    input  logic              dc_mode,
    input  logic [NUM_CH-1:0] open_flags,
    output cfg_ctl_t          ctl,
    output logic [NUM_CH-1:0] lod_cap
);

    upd_state_e state_q, state_d;
    logic       latch_q;
    logic       latch_fall;
    mode_e      mode;

    assign mode       = mode_e'(dc_mode);
    assign latch_fall = latch_q & ~latch;

    always_comb begin
        ctl = '0;
        unique case (state_q)
            UPD_IDLE: begin
                ctl.load_gs   = latch & (mode == MODE_GS);
                ctl.load_stat = latch_fall & (mode == MODE_GS);
            end
            UPD_GS_WAIT: begin
                if (shift_en && !latch && mode == MODE_GS) begin
                    ctl.load_gs   = 1'b1;
                    ctl.load_stat = 1'b1;
                    ctl.use_cap   = 1'b1;
                end
            end
            default: ;
        endcase
        ctl.load_dc = latch & (mode == MODE_DC);
        ctl.shift   = shift_en & ~latch & ~ctl.load_stat;
    end

    always_comb begin
        state_d = state_q;
        if (latch && mode == MODE_DC) begin
            state_d = UPD_DC_DONE;
        end else begin
            unique case (state_q)
                UPD_DC_DONE: if (latch && mode == MODE_GS) state_d = UPD_GS_WAIT;
                UPD_GS_WAIT: if (ctl.load_stat)            state_d = UPD_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UPD_IDLE;
            latch_q <= 1'b0;
            lod_cap <= '0;
        end else begin
            state_q <= state_d;
            latch_q <= latch;
            if (latch_fall) lod_cap <= open_flags;
        end
    end

    // R7: flags are taken on the falling edge of the latch and kept otherwise
    assert_lod_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !latch) |=> (lod_cap == $past(open_flags)));
    assert_lod_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(latch_q && !latch) |=> $stable(lod_cap));
    // R9: while a trim write is pending, a brightness latch does not commit
    assert_pending_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == UPD_DC_DONE) |-> !ctl.load_gs && !ctl.load_stat);

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
    import ledcfg_pkg::*;
#(
    parameter int LEN     = GS_LEN,
    parameter int ALT_LEN = DC_LEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sin,
    input  logic           shift,
    input  logic           load_stat,
    input  logic [LEN-1:0] stat_word,
    input  logic           dc_mode,
    output logic [LEN-1:0] chain,
    output logic           ser_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (load_stat) begin
            chain <= stat_word;
        end else if (shift) begin
            chain <= {chain[LEN-2:0], sin};
        end
    end

    assign ser_out = dc_mode ? chain[ALT_LEN-1] : chain[LEN-1];

    // R1: a shift moves every bit up one place and takes the serial input
    assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
        (shift && !load_stat) |=> (chain == {$past(chain[LEN-2:0]), $past(sin)}));
    // R5: status load replaces the whole chain
    assert_stat_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_stat |=> (chain == $past(stat_word)));
    // R1: no strobe, no movement
    assert_chain_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!shift && !load_stat) |=> $stable(chain));

endmodule

// File: rtl/cfg_data_regs.sv
module cfg_data_regs
    import ledcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_gs,
    input  logic              load_dc,
    input  logic [GS_LEN-1:0] chain,
    output logic [GS_LEN-1:0] gs_q,
    output logic [DC_LEN-1:0] dc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gs_q <= '0;
            dc_q <= '0;
        end else begin
            if (load_gs) gs_q <= chain;
            if (load_dc) dc_q <= chain[DC_LEN-1:0];
        end
    end

    // R3: brightness register takes the chain on a latch and holds otherwise
    assert_gs_load_R3: assert property (@(posedge clk) disable iff (rst)
        load_gs |=> (gs_q == $past(chain)));
    assert_gs_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load_gs |=> $stable(gs_q));
    // R4: trim register takes the low part of the chain
    assert_dc_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_dc |=> (dc_q == $past(chain[DC_LEN-1:0])));
    assert_dc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load_dc |=> $stable(dc_q));

endmodule

// File: rtl/led_cfg_serial.sv
module led_cfg_serial
    import ledcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sin,
    input  logic              shift_en,
    input  logic              latch,
    input  logic              dc_mode,
    input  logic              dc_src_reg,
    input  logic [NUM_CH-1:0] open_flags,
    input  logic              thermal_flag,
    output logic              ser_out,
    output logic [GS_LEN-1:0] gs_data,
    output logic [DC_LEN-1:0] dc_data
);

    cfg_ctl_t          ctl;
    logic [NUM_CH-1:0] lod_cap;
    logic [NUM_CH-1:0] lod_sel;
    logic [DC_LEN-1:0] dc_sel;
    logic [GS_LEN-1:0] stat_word;
    logic [GS_LEN-1:0] chain;

    cfg_update_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .latch      (latch),
        .dc_mode    (dc_mode),
        .open_flags (open_flags),
        .ctl        (ctl),
        .lod_cap    (lod_cap)
    );

    assign lod_sel   = ctl.use_cap ? lod_cap : open_flags;
    assign dc_sel    = dc_src_reg ? dc_data : NV_DC_IMAGE;
    assign stat_word = pack_status(lod_sel, thermal_flag, dc_sel);

    cfg_shift_chain #(
        .LEN     (GS_LEN),
        .ALT_LEN (DC_LEN)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .sin       (sin),
        .shift     (ctl.shift),
        .load_stat (ctl.load_stat),
        .stat_word (stat_word),
        .dc_mode   (dc_mode),
        .chain     (chain),
        .ser_out   (ser_out)
    );

    cfg_data_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .load_gs (ctl.load_gs),
        .load_dc (ctl.load_dc),
        .chain   (chain),
        .gs_q    (gs_data),
        .dc_q    (dc_data)
    );

    // R5: reserved status bits come out as zero after a status load
    assert_stat_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.load_stat |=> (chain[GS_LEN-1:ST_DC_LSB+DC_LEN] == '0) &&
                          (chain[ST_DC_LSB-1:ST_TEF_POS+1] == '0));
    // R8: the status MSB is reserved, so brightness-mode output is low right after the load
    assert_stat_msb_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_stat && !dc_mode) |=> !ser_out || dc_mode);

endmodule

// File: tb/led_cfg_serial_test.sv
module led_cfg_serial_test;
    import ledcfg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sin = 1'b0;
    logic              shift_en = 1'b0;
    logic              latch = 1'b0;
    logic              dc_mode = 1'b0;
    logic              dc_src_reg = 1'b0;
    logic [NUM_CH-1:0] open_flags = '0;
    logic              thermal_flag = 1'b0;
    logic              ser_out;
    logic [GS_LEN-1:0] gs_data;
    logic [DC_LEN-1:0] dc_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    led_cfg_serial uut (
        .clk          (clk),
        .rst          (rst),
        .sin          (sin),
        .shift_en     (shift_en),
        .latch        (latch),
        .dc_mode      (dc_mode),
        .dc_src_reg   (dc_src_reg),
        .open_flags   (open_flags),
        .thermal_flag (thermal_flag),
        .ser_out      (ser_out),
        .gs_data      (gs_data),
        .dc_data      (dc_data)
    );

    function automatic logic [191:0] rand192();
        logic [191:0] v;
        for (int i = 0; i < 6; i++) v[32*i +: 32] = $urandom();
        return v;
    endfunction

    // status word from the requirement text, bit by bit
    function automatic logic [191:0] exp_status(input logic [15:0] lod, input logic tef,
                                                input logic [95:0] trim);
        logic [191:0] w;
        for (int b = 0; b < 192; b++) begin
            if (b < 16)                  w[b] = lod[b];
            else if (b == 16)            w[b] = tef;
            else if (b >= 24 && b < 120) w[b] = trim[b-24];
            else                         w[b] = 1'b0;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [191:0] got, input logic [191:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [191:0] v, input int n, output logic [191:0] seen);
        seen = '0;
        for (int i = n - 1; i >= 0; i--) begin
            seen[i]  = ser_out;
            sin      = v[i];
            shift_en = 1'b1;
            @(negedge clk);
            shift_en = 1'b0;
        end
    endtask

    task automatic do_latch(input logic poke);
        latch    = 1'b1;
        shift_en = poke;
        sin      = 1'b1;
        @(negedge clk);
        latch    = 1'b0;
        shift_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [95:0]  dcv;
        logic [5:0]   ch [16];
        logic [191:0] gv, nxt, seen;
        logic [15:0]  f;
        logic         tef_v;
        logic         src_v;

        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 gs_data", gs_data, '0);
        check("R11 dc_data", {96'd0, dc_data}, '0);
        check("R11 ser_out", {191'd0, ser_out}, '0);

        // R4: trim write, channel by channel
        dc_mode = 1'b1;
        for (int n = 0; n < 16; n++) begin
            ch[n] = 6'($urandom());
            dcv[6*n +: 6] = ch[n];
        end
        shift_bits({96'd0, dcv}, 96, seen);
        do_latch(1'b0);
        check("R4 dc_data", {96'd0, dc_data}, {96'd0, dcv});
        check("R4 ch15 field", {186'd0, dc_data[95:90]}, {186'd0, ch[15]});
        check("R4 ch0 field", {186'd0, dc_data[5:0]}, {186'd0, ch[0]});
        check("R3 gs hold over trim latch", gs_data, '0);
        // R2: trim-mode tap is bit 95
        check("R2 dc tap", {191'd0, ser_out}, {191'd0, dcv[95]});
        shift_bits(192'd0, 1, seen);
        check("R2 dc tap after shift", {191'd0, ser_out}, {191'd0, dcv[94]});

        // R9: pending commit after trim write, status from trim register (R6)
        dc_mode      = 1'b0;
        dc_src_reg   = 1'b1;
        thermal_flag = 1'b1;
        f            = 16'($urandom());
        open_flags   = f;
        gv           = rand192();
        shift_bits(gv, 192, seen);
        do_latch(1'b0);
        check("R9 gs_data not yet committed", gs_data, '0);
        check("R9 chain kept after fall", {191'd0, ser_out}, {191'd0, gv[191]});
        open_flags = ~f;
        sin = 1'b0;
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        check("R9 commit on extra strobe", gs_data, gv);
        check("R8 status msb", {191'd0, ser_out}, '0);
        nxt = rand192();
        shift_bits(nxt, 192, seen);
        check("R5 R6 R7 R9 status readback", seen, exp_status(f, 1'b1, dcv));
        gv = nxt;

        // R1 strobe during latch ignored; R10 nonvolatile trim image
        dc_src_reg   = 1'b0;
        thermal_flag = 1'b0;
        f            = 16'($urandom());
        open_flags   = f;
        do_latch(1'b1);
        check("R1 R3 latch with strobe", gs_data, gv);
        open_flags = 16'($urandom());
        nxt = rand192();
        shift_bits(nxt, 192, seen);
        check("R10 R7 status readback", seen, exp_status(f, 1'b0, {96{1'b1}}));
        check("R3 hold without latch", gs_data, gv);
        gv = nxt;

        // R3 R5 R6 R8: random frames
        for (int it = 0; it < 8; it++) begin
            src_v        = 1'($urandom());
            tef_v        = 1'($urandom());
            f            = 16'($urandom());
            dc_src_reg   = src_v;
            thermal_flag = tef_v;
            open_flags   = f;
            do_latch(1'b0);
            check("R3 random latch", gs_data, gv);
            open_flags = 16'($urandom());
            nxt = rand192();
            shift_bits(nxt, 192, seen);
            check("R5 R6 R8 random readback", seen,
                  exp_status(f, tef_v, src_v ? dcv : {96{1'b1}}));
            gv = nxt;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule